// File: doc/BRIEF.md
# Dual-Channel Shadowed PWM Generator

This block is a memory-mapped pulse-width modulator with two independent output channels. Each channel is set up through four word registers (control, clock prescaler, period count and duty count) on a simple word bus with write and read strobes. A written value first lands in a shadow register. It then passes a two-stage synchronisation pipeline, and only after that can it reach the counter logic. While a write is still in that pipeline, a pending flag for that register shows in a shared, read-only status word. Software polls this word until the flag drops before it relies on the new value.

Every counter-side value sits in two stages: a staged copy that follows the shadow, and an active copy that the counters use. In autoload mode the staged prescaler, period and duty move into the active set when the current output period ends. In manual mode they move only when software writes the control register with a load strobe. A disabled channel either finishes its current period or stops at once, depending on a control bit. The output can be inverted. The slots for a third and fourth channel are reserved and not built.

Top module: `pwm2_top`

## Requirements
- R1: Channel c's registers are at byte address c*0x10 plus 0x0 (control), 0x4 (prescaler), 0x8 (period) and 0xC (duty). A read returns the stored value masked to its width: control 4 bits, prescaler 10 bits, period 12 bits, duty 12 bits. The control load strobes (bits 4 and 5) always read as zero.
- R2: The slots at 0x20 and 0x30 and any unaligned address read as zero. Writes to them change no register and set no pending flag.
- R3: The status word at 0x40 is read-only, and a write to it is ignored. Channel 0's flags are at bits [3:0] and channel 1's at bits [11:8]. Inside each nibble, bit 0 is control, bit 1 is prescaler, bit 2 is period and bit 3 is duty.
- R4: A register write sets its pending flag, visible in the cycle right after the write edge. The flag stays set for exactly two clock cycles after the last write to that register and then drops by itself.
- R5: Control bit 0 enables the channel. A running channel repeats a period of (prescaler+1)*(period+1) clocks. If duty < period, it is active for duty*(prescaler+1) clocks at the start of each period. If duty >= period, it is active for the whole period.
- R6: Control bit 1 inverts the output level, both while running and while idle. A stopped, non-inverted channel idles low.
- R7: With control bit 2 (autoload) set, new staged prescaler, period and duty values take effect at the end of the current period, or at once while the channel is stopped.
- R8: With autoload clear, staged values are not used until a control write with bit 4 loads the prescaler, or with bit 5 loads period and duty. The load also restarts the period.
- R9: Clearing enable while control bit 3 (stop now) is clear lets the current period run to its end. After that the output stays at the idle level.
- R10: Clearing enable with stop now set idles the output within two cycles after the control write takes effect.
- R11: The two channels count and are configured independently.
- R12: After reset, all registers and the status word read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counters |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 12 | Read data, zero when no read is strobed |
| pwm_out | output | 2 | One PWM output per channel |

## Verification
The assertions check on every cycle that each pending flag rises after its write and drops exactly three edges later. They also check that the counters never pass their active limits, that the active period changes only at a period end or on a load, and that an immediate stop ends the run on the next edge while a graceful stop does not end it early. Only the bench scenarios can show the end-to-end waveform: active-cycle counts and period lengths over whole periods, inversion, that staged values stay unused until a manual load, and that the idle level holds after each kind of stop.

// File: rtl/pwm2_pkg.sv
// Shared widths, register map constants and the control word layout.
package pwm2_pkg;
    localparam int NUM_CH        = 2;
    localparam int NUM_SLOTS     = 4;
    localparam int NUM_SEL       = 4;
    localparam int PRESC_W       = 10;
    localparam int PER_W         = 12;
    localparam int SLOT_BYTES    = 16;
    localparam int STATUS_STRIDE = 8;
    localparam int LOAD_W        = 2;
    localparam int STATUS_ADDR   = NUM_SLOTS * SLOT_BYTES;
    localparam int ADDR_W        = $clog2(STATUS_ADDR) + 1;
    localparam int SLOT_W        = $clog2(NUM_SLOTS);
    localparam int SEL_W         = $clog2(NUM_SEL);
    localparam int STATUS_W      = (NUM_CH - 1) * STATUS_STRIDE + NUM_SEL;
    localparam int BUS_W         = (PER_W > STATUS_W) ? PER_W : STATUS_W;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_PRESC = 2'd1,
        SEL_PER   = 2'd2,
        SEL_DUTY  = 2'd3
    } sel_e;

    typedef struct packed {
        logic stop_now;
        logic autoload;
        logic invert;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm2_regfile.sv
// Register decode, shadow registers, pending-update pipeline and read mux.
// Assumes word-aligned accesses; one access per cycle; reads are combinational.
module pwm2_regfile
    import pwm2_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_wr,
    input  logic                                bus_rd,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [BUS_W-1:0]                    bus_wdata,
    output logic [BUS_W-1:0]                    bus_rdata,
    output ctrl_t [NUM_CH-1:0]                  sh_ctrl,
    output logic [NUM_CH-1:0][LOAD_W-1:0]       sh_load,
    output logic [NUM_CH-1:0][PRESC_W-1:0]      sh_presc,
    output logic [NUM_CH-1:0][PER_W-1:0]        sh_per,
    output logic [NUM_CH-1:0][PER_W-1:0]        sh_duty,
    output logic [NUM_CH-1:0][NUM_SEL-1:0]      absorb
);
    logic                          word_ok, in_chan, in_stat;
    logic [SLOT_W-1:0]             slot;
    logic [SEL_W-1:0]              sel;
    logic [NUM_CH-1:0][NUM_SEL-1:0] wr_hit, sync1, sync2, pend;
    logic [STATUS_W-1:0]           status;

    assign word_ok = (bus_addr[1:0] == 2'b00);
    assign in_chan = word_ok && (bus_addr[ADDR_W-1] == 1'b0);
    assign in_stat = (bus_addr == ADDR_W'(STATUS_ADDR));
    assign slot    = bus_addr[2+SEL_W +: SLOT_W];
    assign sel     = bus_addr[2 +: SEL_W];

    // One-hot write select per implemented channel and register.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            wr_hit[c] = '0;
            if (bus_wr && in_chan && slot == SLOT_W'(c))
                wr_hit[c] = NUM_SEL'(1) << sel;
        end
    end

    // Shadow registers capture bus data on their write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_ctrl  <= '0;
            sh_load  <= '0;
            sh_presc <= '0;
            sh_per   <= '0;
            sh_duty  <= '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_hit[c][SEL_CTRL]) begin
                    sh_ctrl[c] <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
                    sh_load[c] <= bus_wdata[CTRL_W +: LOAD_W];
                end
                if (wr_hit[c][SEL_PRESC]) sh_presc[c] <= bus_wdata[PRESC_W-1:0];
                if (wr_hit[c][SEL_PER])   sh_per[c]   <= bus_wdata[PER_W-1:0];
                if (wr_hit[c][SEL_DUTY])  sh_duty[c]  <= bus_wdata[PER_W-1:0];
            end
        end
    end

    // Two-stage synchroniser of write events toward the counter side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
        end else begin
            sync1 <= wr_hit;
            sync2 <= sync1;
        end
    end

    assign pend   = sync1 | sync2;
    assign absorb = sync2;

    // Pack each channel's pending nibble at its stride in the status word.
    always_comb begin
        status = '0;
        for (int c = 0; c < NUM_CH; c++)
            status[c*STATUS_STRIDE +: NUM_SEL] = pend[c];
    end

    // Read mux; reserved slots and unknown offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (in_stat) begin
                bus_rdata = BUS_W'(status);
            end else if (in_chan) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (slot == SLOT_W'(c)) begin
                        case (sel_e'(sel))
                            SEL_CTRL:  bus_rdata = BUS_W'(sh_ctrl[c]);
                            SEL_PRESC: bus_rdata = BUS_W'(sh_presc[c]);
                            SEL_PER:   bus_rdata = BUS_W'(sh_per[c]);
                            default:   bus_rdata = BUS_W'(sh_duty[c]);
                        endcase
                    end
                end
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk_ch
        for (genvar r = 0; r < NUM_SEL; r++) begin : g_chk_reg
            // R4: a write raises its pending flag on the next edge.
            assert_pend_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hit[c][r] |=> pend[c][r]);
            // R4: a flag drops only three edges after its last write.
            assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pend[c][r]) |-> ($past(wr_hit[c][r], 3) && !$past(wr_hit[c][r], 2)
                                        && !$past(wr_hit[c][r])));
        end
    end
endmodule

// File: rtl/pwm2_timebase.sv
// Prescaler and period counters of one channel.
// Assumes the limits change only while clr is high or on the edge after last.
module pwm2_timebase
    import pwm2_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               adv,
    input  logic [PRESC_W-1:0] presc_lim,
    input  logic [PER_W-1:0]   per_lim,
    output logic [PER_W-1:0]   cnt,
    output logic               last
);
    logic [PRESC_W-1:0] pc;

    assign last = (pc == presc_lim) && (cnt == per_lim);

    // Prescaler ticks the period counter; both wrap at their limits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pc  <= '0;
            cnt <= '0;
        end else if (adv) begin
            if (pc == presc_lim) begin
                pc  <= '0;
                cnt <= (cnt == per_lim) ? '0 : cnt + 1'b1;
            end else begin
                pc <= pc + 1'b1;
            end
        end
    end

    // R5: counters never run past the active limits.
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc <= presc_lim) && (cnt <= per_lim));
endmodule

// File: rtl/pwm2_chan.sv
// One PWM channel: staged and active value sets, run control and output level.
// Assumes absorb pulses come from the write synchroniser, one per write.
module pwm2_chan
    import pwm2_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  ctrl_t               sh_ctrl,
    input  logic [LOAD_W-1:0]   sh_load,
    input  logic [PRESC_W-1:0]  sh_presc,
    input  logic [PER_W-1:0]    sh_per,
    input  logic [PER_W-1:0]    sh_duty,
    input  logic [NUM_SEL-1:0]  absorb,
    output logic                pwm_o
);
    ctrl_t              ctrl_act;
    logic [PRESC_W-1:0] stg_presc, act_presc;
    logic [PER_W-1:0]   stg_per, act_per, stg_duty, act_duty, cnt;
    logic               run, last, period_end, load_p, load_pd, auto_ld, stop_hard, clr, active;

    assign period_end = run && last;
    assign load_p     = absorb[SEL_CTRL] && sh_load[0];
    assign load_pd    = absorb[SEL_CTRL] && sh_load[1];
    assign auto_ld    = ctrl_act.autoload && (period_end || !run);
    assign stop_hard  = run && !ctrl_act.enable && ctrl_act.stop_now;
    assign clr        = !run || stop_hard || load_p || load_pd || (period_end && !ctrl_act.enable);

    // Staged copies and control follow the shadow when a write is absorbed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_act  <= '0;
            stg_presc <= '0;
            stg_per   <= '0;
            stg_duty  <= '0;
        end else begin
            if (absorb[SEL_CTRL])  ctrl_act  <= sh_ctrl;
            if (absorb[SEL_PRESC]) stg_presc <= sh_presc;
            if (absorb[SEL_PER])   stg_per   <= sh_per;
            if (absorb[SEL_DUTY])  stg_duty  <= sh_duty;
        end
    end

    // Active set loads at period end or idle (autoload) or on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_presc <= '0;
            act_per   <= '0;
            act_duty  <= '0;
        end else if (auto_ld) begin
            act_presc <= stg_presc;
            act_per   <= stg_per;
            act_duty  <= stg_duty;
        end else begin
            if (load_p) act_presc <= stg_presc;
            if (load_pd) begin
                act_per  <= stg_per;
                act_duty <= stg_duty;
            end
        end
    end

    // Run state: start on enable, stop at once or at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)                               run <= 1'b0;
        else if (!run)                            run <= ctrl_act.enable;
        else if (stop_hard)                       run <= 1'b0;
        else if (period_end && !ctrl_act.enable)  run <= 1'b0;
    end

    pwm2_timebase u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .adv       (run),
        .presc_lim (act_presc),
        .per_lim   (act_per),
        .cnt       (cnt),
        .last      (last)
    );

    assign active = (act_duty >= act_per) || (cnt < act_duty);
    assign pwm_o  = (run && active) ^ ctrl_act.invert;

    // R10: an immediate stop ends the run on the next edge.
    assert_stop_now_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hard |=> !run);
    // R9: a graceful stop keeps running until the period ends.
    assert_finish_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctrl_act.enable && !ctrl_act.stop_now && !last) |=> run);
    // R7: the active period only changes at a period end or on a load strobe.
    assert_hold_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last && !load_pd) |=> $stable(act_per));
endmodule

// File: rtl/pwm2_top.sv
// Dual-channel PWM top: one register file feeding one channel per output.
// Assumes a single clock for bus and counters, synchronous active-low reset.
module pwm2_top
    import pwm2_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    ctrl_t [NUM_CH-1:0]                 sh_ctrl;
    logic  [NUM_CH-1:0][LOAD_W-1:0]     sh_load;
    logic  [NUM_CH-1:0][PRESC_W-1:0]    sh_presc;
    logic  [NUM_CH-1:0][PER_W-1:0]      sh_per, sh_duty;
    logic  [NUM_CH-1:0][NUM_SEL-1:0]    absorb;

    pwm2_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sh_ctrl   (sh_ctrl),
        .sh_load   (sh_load),
        .sh_presc  (sh_presc),
        .sh_per    (sh_per),
        .sh_duty   (sh_duty),
        .absorb    (absorb)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm2_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .sh_ctrl  (sh_ctrl[c]),
            .sh_load  (sh_load[c]),
            .sh_presc (sh_presc[c]),
            .sh_per   (sh_per[c]),
            .sh_duty  (sh_duty[c]),
            .absorb   (absorb[c]),
            .pwm_o    (pwm_out[c])
        );
    end
endmodule

// File: tb/test_pwm2_top.sv
`timescale 1ns/1ps
module test_pwm2_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [11:0] bus_wdata = '0;
    logic [11:0] bus_rdata;
    logic [1:0]  pwm_out;
    int          checks = 0;
    int          failures = 0;

    typedef struct packed {
        logic [9:0]  presc;
        logic [11:0] per;
        logic [11:0] duty;
        logic        inv;
        logic [7:0]  len;
        logic [7:0]  high;
    } vec_t;

    localparam vec_t VEC [0:6] = '{
        '{10'd0, 12'd9, 12'd5, 1'b0, 8'd10, 8'd5},
        '{10'd1, 12'd4, 12'd2, 1'b0, 8'd10, 8'd4},
        '{10'd2, 12'd3, 12'd1, 1'b1, 8'd12, 8'd9},
        '{10'd0, 12'd7, 12'd7, 1'b0, 8'd8,  8'd8},
        '{10'd0, 12'd7, 12'd0, 1'b0, 8'd8,  8'd0},
        '{10'd3, 12'd5, 12'd9, 1'b0, 8'd24, 8'd24},
        '{10'd0, 12'd0, 12'd0, 1'b0, 8'd1,  8'd1}
    };

    pwm2_top i_pwm2_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [11:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output int v);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        v = int'(bus_rdata);
        bus_rd = 1'b0;
    endtask

    task automatic meas(input int ch, input int n, output int hi, output int rises);
        logic prev;
        prev = pwm_out[ch];
        hi = 0; rises = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
            if (pwm_out[ch] && !prev) rises++;
            prev = pwm_out[ch];
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        prev = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int v, hi, rs;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 outputs", int'(pwm_out), 0);
        rd(7'h40, v); chk("R12 status", v, 0);
        rd(7'h08, v); chk("R12 period reg", v, 0);

        // R2: reserved slot is inert
        wr(7'h28, 12'h123);
        rd(7'h28, v); chk("R2 reserved read", v, 0);
        rd(7'h40, v); chk("R2 no pending from reserved", v, 0);
        rd(7'h08, v); chk("R2 ch0 period untouched", v, 0);
        wr(7'h09, 12'h456);
        rd(7'h08, v); chk("R2 unaligned write ignored", v, 0);

        // R3: status is read-only
        wr(7'h40, 12'hFFF);
        rd(7'h40, v); chk("R3 status write ignored", v, 0);

        // R4 / R3: pending flag position and lifetime (ch1 period -> bit 10)
        wr(7'h18, 12'd3);
        rd(7'h40, v); chk("R4 ch1 period pending first", v, 12'h400);
        @(negedge clk);
        rd(7'h40, v); chk("R4 ch1 period pending second", v, 12'h400);
        @(negedge clk);
        rd(7'h40, v); chk("R4 ch1 period cleared", v, 0);
        wr(7'h04, 12'hFFF);
        rd(7'h40, v); chk("R3 ch0 prescaler bit1", v, 12'h002);

        // R1: readback widths and strobe bits
        rd(7'h04, v); chk("R1 prescaler masked", v, 12'h3FF);
        wr(7'h0C, 12'hABC);
        rd(7'h0C, v); chk("R1 duty readback", v, 12'hABC);
        wr(7'h00, 12'h03A);
        rd(7'h00, v); chk("R1 control strobes read zero", v, 12'h00A);

        // ch1 setup: presc 0, period 3, duty 1, autoload+enable
        wr(7'h14, 12'd0);
        wr(7'h1C, 12'd1);
        wr(7'h10, 12'h005);

        // R5 R6 R7: table-driven waveform checks on ch0 with autoload
        for (int k = 0; k < 7; k++) begin
            wr(7'h04, 12'(VEC[k].presc));
            wr(7'h08, VEC[k].per);
            wr(7'h0C, VEC[k].duty);
            wr(7'h00, 12'h005 | (12'(VEC[k].inv) << 1));
            repeat (100) @(negedge clk);
            meas(0, 4 * int'(VEC[k].len), hi, rs);
            chk($sformatf("R5 R6 R7 vector %0d high count", k), hi, 4 * int'(VEC[k].high));
        end

        // R11: ch1 unaffected by ch0 traffic, 1 of 4 high
        meas(1, 40, hi, rs);
        chk("R11 ch1 independent", hi, 10);

        // R8: manual load behaviour
        wr(7'h04, 12'd0); wr(7'h08, 12'd9); wr(7'h0C, 12'd5); wr(7'h00, 12'h005);
        repeat (60) @(negedge clk);
        meas(0, 100, hi, rs); chk("R8 baseline", hi, 50);
        wr(7'h00, 12'h001);
        wr(7'h0C, 12'd2);
        repeat (50) @(negedge clk);
        meas(0, 100, hi, rs); chk("R8 staged duty unused", hi, 50);
        wr(7'h00, 12'h021);
        repeat (20) @(negedge clk);
        meas(0, 100, hi, rs); chk("R8 period/duty load", hi, 20);
        wr(7'h04, 12'd2);
        repeat (40) @(negedge clk);
        meas(0, 300, hi, rs); chk("R8 staged prescaler unused", rs, 30);
        wr(7'h00, 12'h011);
        repeat (40) @(negedge clk);
        meas(0, 300, hi, rs); chk("R8 prescaler load", rs, 10);

        // R9: graceful stop finishes the period
        wr(7'h04, 12'd0); wr(7'h08, 12'd99); wr(7'h0C, 12'd50); wr(7'h00, 12'h005);
        repeat (250) @(negedge clk);
        wait_rise(0);
        wr(7'h00, 12'h004);
        repeat (3) @(negedge clk);
        chk("R9 still running after disable", int'(pwm_out[0]), 1);
        repeat (120) @(negedge clk);
        meas(0, 100, hi, rs); chk("R9 idle after period end", hi, 0);

        // R10: immediate stop
        wr(7'h00, 12'h005);
        repeat (150) @(negedge clk);
        wait_rise(0);
        wr(7'h00, 12'h00C);
        repeat (3) @(negedge clk);
        chk("R10 idle at once", int'(pwm_out[0]), 0);

        // R6: inverted idle level
        wr(7'h00, 12'h006);
        repeat (4) @(negedge clk);
        chk("R6 inverted idle high", int'(pwm_out[0]), 1);

        finish_run();
    end
endmodule